// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block lays a square cursor image over a stream of display pixels. Each incoming beat carries the raster X/Y position of the pixel, its background colour and alpha, and start-of-frame / end-of-line markers. The block checks whether that position falls inside the cursor square. If it does, the block combines a texel from an internal cursor image with the background, using either a factor-based alpha blend or a simple replace-if-opaque rule. The result leaves two register stages later on an output stream, with the markers kept aligned to their pixel.

The cursor image is held in a small on-chip RGBA store of 32x32 texels, loaded through a plain write port. The cursor edge can be 32, 64, 128 or 256 pixels. For sizes above 32, each texel is stretched over a 2x2, 4x4 or 8x8 block of screen pixels. Position, size, enable, blend settings and global alpha are plain level inputs. They must stay steady while pixels are in flight. A clip-target field is registered only so that it can be read back. It has no effect on pixels.

Both streams use valid/ready. A beat moves when valid and ready are both high at a rising clock edge. The output holds all its fields steady while valid is high and ready is low. The input reports ready whenever the output stage is empty or is being drained in that cycle. A stall at the output therefore halts the whole pipeline without losing any pixel.

Top module: `cursor_overlay`

## Requirements
- R1: `cur_size` selects a square cursor edge of 32 (0), 64 (1), 128 (2) or 256 (3) pixels.
- R2: `cur_pos` carries cursor X in bits 13:0 and cursor Y in bits 29:16; bits 31:30 and 15:14 are ignored. A pixel is inside when 0 <= x-X < edge and 0 <= y-Y < edge, with no wrap-around.
- R3: When `cur_en` is low, or the pixel is outside the cursor, the output colour equals the background colour.
- R4: The texel word is {alpha[31:24], red[23:16], green[15:8], blue[7:0]}, stored at address row*32+col. Inside the cursor, the texel used is row=(y-Y)>>cur_size, col=(x-X)>>cur_size.
- R5: Source factor: `blend_src_sel`=0 gives K1; 1 gives round(K1*Ta/255), where K1 is `blend_k1` and Ta is the texel alpha.
- R6: Destination factor: `blend_dst_sel` 0 gives zero, 1 gives K1, 2 gives 255-round(K1*Ta/255), and 3 behaves as zero.
- R7: In normal mode (`blend_normal`=1), each colour channel is (T*sf + B*df + 127)/255, saturated at 255. The output alpha always equals the background alpha.
- R8: In legacy mode (`blend_normal`=0), an inside pixel whose texel alpha is nonzero takes the texel colour outright. An inside pixel with zero texel alpha keeps the background.
- R9: A pixel accepted at edge E appears on the output after edge E+1 when not stalled. `out_sof`/`out_eol` travel with their pixel.
- R10: While `out_valid` is high and `out_ready` is low, every output field holds steady. `in_ready` is high whenever `out_valid` is low, and no pixel is dropped or duplicated.
- R11: `clip_readback` returns `cur_clip` one cycle later, and its value never changes a pixel.
- R12: After reset, `out_valid` is low, `in_ready` is high and `clip_readback` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_x | input | 14 | Raster X of the pixel |
| in_y | input | 14 | Raster Y of the pixel |
| in_rgb | input | 24 | Background colour {R,G,B} |
| in_alpha | input | 8 | Background alpha |
| in_sof | input | 1 | Start-of-frame marker |
| in_eol | input | 1 | End-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts output |
| out_rgb | output | 24 | Composited colour {R,G,B} |
| out_alpha | output | 8 | Background alpha, passed through |
| out_sof | output | 1 | Start-of-frame marker, aligned |
| out_eol | output | 1 | End-of-line marker, aligned |
| cur_en | input | 1 | Cursor overlay enable |
| cur_size | input | 2 | Cursor edge code |
| cur_pos | input | 32 | Cursor position word |
| cur_clip | input | 2 | Clip target (0 display, 1..3 windows) |
| clip_readback | output | 2 | Registered clip target |
| blend_normal | input | 1 | 1 alpha blend, 0 legacy replace |
| blend_src_sel | input | 1 | Source factor encoding |
| blend_dst_sel | input | 2 | Destination factor encoding |
| blend_k1 | input | 8 | Global alpha K1 (255 opaque) |
| tex_wr_en | input | 1 | Cursor image write strobe |
| tex_wr_addr | input | 10 | Texel address row*32+col |
| tex_wr_data | input | 32 | Texel {A,R,G,B} |

## Verification
On every cycle, the checker enforces the stream rules: output fields stay steady under stall, ready is raised when the output is empty, and an output beat only follows an occupied first stage. It also checks three stage-to-stage relations: a miss passes the background colour through, legacy mode copies an opaque texel, and alpha passes through unchanged. Clip readback is checked the same way. Only the bench's sweeps can show the hit geometry for each size code, the texel stretching, and the arithmetic of every source/destination factor combination including saturation. The bench sweeps rows and columns across the cursor edges, under both steady and random output back-pressure, and compares each beat against an arithmetic model.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int COORD_W = 14;   // fixed by the position word layout
  localparam int CH_W    = 8;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } texel_t;

  // round(a*b/255)
  function automatic logic [7:0] scale255(input logic [7:0] a, input logic [7:0] b);
    logic [16:0] p;
    p = 17'(a) * 17'(b) + 17'd127;
    return 8'(p / 17'd255);
  endfunction

  // (s*sf + d*df + 127)/255, saturated to 8 bits
  function automatic logic [7:0] mix8(input logic [7:0] s, input logic [7:0] sf,
                                      input logic [7:0] d, input logic [7:0] df);
    logic [17:0] sum;
    logic [17:0] q;
    sum = 18'(s) * 18'(sf) + 18'(d) * 18'(df) + 18'd127;
    q   = sum / 18'd255;
    return (q > 18'd255) ? 8'hFF : q[7:0];
  endfunction
endpackage

// File: rtl/cur_texmem.sv
module cur_texmem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cur_hit.sv
module cur_hit import cur_pkg::*; #(
  parameter int BASE_LOG2 = 5
) (
  input  logic               en,
  input  logic [1:0]         size_code,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  output logic               hit,
  output logic [2*BASE_LOG2-1:0] addr
);
  localparam int DW = COORD_W + 1;
  logic [DW-1:0] dx, dy, edge_len;
  logic [BASE_LOG2-1:0] col, row;

  always_comb begin
    dx       = {1'b0, x} - {1'b0, pos_x};
    dy       = {1'b0, y} - {1'b0, pos_y};
    edge_len = DW'(1) << (BASE_LOG2 + int'(size_code));
    hit = en && !dx[DW-1] && !dy[DW-1] && (dx < edge_len) && (dy < edge_len);
    col = BASE_LOG2'(dx[COORD_W-1:0] >> size_code);
    row = BASE_LOG2'(dy[COORD_W-1:0] >> size_code);
    addr = {row, col};
  end
endmodule

// File: rtl/cur_blend.sv
module cur_blend import cur_pkg::*; (
  input  logic        hit,
  input  logic        normal,
  input  logic        src_sel,
  input  logic [1:0]  dst_sel,
  input  logic [7:0]  k1,
  input  texel_t      tex,
  input  logic [23:0] bg_rgb,
  output logic [23:0] rgb
);
  logic [7:0]  k1a, sf, df;
  logic [23:0] tex_rgb, mixed;

  assign tex_rgb = {tex.r, tex.g, tex.b};
  assign k1a     = scale255(k1, tex.a);
  assign sf      = src_sel ? k1a : k1;

  always_comb begin
    unique case (dst_sel)
      2'd1:    df = k1;
      2'd2:    df = 8'hFF - k1a;
      default: df = 8'h00;
    endcase
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign mixed[8*c +: 8] = mix8(tex_rgb[8*c +: 8], sf, bg_rgb[8*c +: 8], df);
  end

  always_comb begin
    if (!hit)         rgb = bg_rgb;
    else if (normal)  rgb = mixed;
    else              rgb = (tex.a != 8'h00) ? tex_rgb : bg_rgb;
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import cur_pkg::*; #(
  parameter int BASE_LOG2 = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [13:0]            in_x,
  input  logic [13:0]            in_y,
  input  logic [23:0]            in_rgb,
  input  logic [7:0]             in_alpha,
  input  logic                   in_sof,
  input  logic                   in_eol,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [23:0]            out_rgb,
  output logic [7:0]             out_alpha,
  output logic                   out_sof,
  output logic                   out_eol,
  input  logic                   cur_en,
  input  logic [1:0]             cur_size,
  input  logic [31:0]            cur_pos,
  input  logic [1:0]             cur_clip,
  output logic [1:0]             clip_readback,
  input  logic                   blend_normal,
  input  logic                   blend_src_sel,
  input  logic [1:0]             blend_dst_sel,
  input  logic [7:0]             blend_k1,
  input  logic                   tex_wr_en,
  input  logic [2*BASE_LOG2-1:0] tex_wr_addr,
  input  logic [31:0]            tex_wr_data
);
  localparam int TEX_AW = 2 * BASE_LOG2;
  localparam int Y_LSB  = 16;

  logic               adv;
  logic               hit;
  logic [TEX_AW-1:0]  rd_addr;
  logic [31:0]        tex_word;
  logic [23:0]        blended;
  logic               unused_pos_bits;

  logic               s1_valid, s1_hit, s1_sof, s1_eol;
  logic [23:0]        s1_bg;
  logic [7:0]         s1_alpha;
  texel_t             s1_tex;

  assign unused_pos_bits = ^{cur_pos[31:Y_LSB+COORD_W], cur_pos[Y_LSB-1:COORD_W]};

  // whole pipeline advances when the output register is free or draining
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  cur_hit #(.BASE_LOG2(BASE_LOG2)) u_hit (
    .en        (cur_en),
    .size_code (cur_size),
    .x         (in_x),
    .y         (in_y),
    .pos_x     (cur_pos[COORD_W-1:0]),
    .pos_y     (cur_pos[Y_LSB+COORD_W-1:Y_LSB]),
    .hit       (hit),
    .addr      (rd_addr)
  );

  cur_texmem #(.AW(TEX_AW), .DW(32)) u_mem (
    .clk     (clk),
    .wr_en   (tex_wr_en),
    .wr_addr (tex_wr_addr),
    .wr_data (tex_wr_data),
    .rd_en   (adv),
    .rd_addr (rd_addr),
    .rd_data (tex_word)
  );

  assign s1_tex = texel_t'(tex_word);

  // stage 1: hit decision, texel fetch, background capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_sof   <= 1'b0;
      s1_eol   <= 1'b0;
      s1_bg    <= '0;
      s1_alpha <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_hit   <= hit;
      s1_sof   <= in_sof;
      s1_eol   <= in_eol;
      s1_bg    <= in_rgb;
      s1_alpha <= in_alpha;
    end
  end

  cur_blend u_blend (
    .hit     (s1_hit),
    .normal  (blend_normal),
    .src_sel (blend_src_sel),
    .dst_sel (blend_dst_sel),
    .k1      (blend_k1),
    .tex     (s1_tex),
    .bg_rgb  (s1_bg),
    .rgb     (blended)
  );

  // stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_alpha <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_rgb   <= blended;
      out_alpha <= s1_alpha;
      out_sof   <= s1_sof;
      out_eol   <= s1_eol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clip_readback <= 2'd0;
    else        clip_readback <= cur_clip;
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_rgb,
  input logic [7:0]  out_alpha,
  input logic        out_sof,
  input logic        out_eol,
  input logic        s1_valid,
  input logic        s1_hit,
  input logic [23:0] s1_bg,
  input logic [7:0]  s1_alpha,
  input logic [31:0] s1_tex,
  input logic        blend_normal,
  input logic [1:0]  cur_clip,
  input logic [1:0]  clip_readback
);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_alpha)
                                && $stable(out_sof) && $stable(out_eol));
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R9
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));
  // R3
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && s1_valid && !s1_hit |=> out_rgb == $past(s1_bg));
  // R8
  legacy_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && s1_valid && s1_hit && !blend_normal && (s1_tex[31:24] != 8'h00)
    |=> out_rgb == $past(s1_tex[23:0]));
  // R7
  alpha_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && s1_valid |=> out_alpha == $past(s1_alpha));
  // R11
  clip_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> clip_readback == $past(cur_clip));
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_rgb       (out_rgb),
  .out_alpha     (out_alpha),
  .out_sof       (out_sof),
  .out_eol       (out_eol),
  .s1_valid      (s1_valid),
  .s1_hit        (s1_hit),
  .s1_bg         (s1_bg),
  .s1_alpha      (s1_alpha),
  .s1_tex        (tex_word),
  .blend_normal  (blend_normal),
  .cur_clip      (cur_clip),
  .clip_readback (clip_readback)
);

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 0, in_ready, in_sof = 0, in_eol = 0;
  logic [13:0] in_x = 0, in_y = 0;
  logic [23:0] in_rgb = 0;
  logic [7:0]  in_alpha = 0;
  logic        out_valid, out_ready = 1, out_sof, out_eol;
  logic [23:0] out_rgb;
  logic [7:0]  out_alpha;
  logic        cur_en = 0, blend_normal = 1, blend_src_sel = 0;
  logic [1:0]  cur_size = 0, cur_clip = 0, clip_readback, blend_dst_sel = 0;
  logic [31:0] cur_pos = 0;
  logic [7:0]  blend_k1 = 8'hFF;
  logic        tex_wr_en = 0;
  logic [9:0]  tex_wr_addr = 0;
  logic [31:0] tex_wr_data = 0;

  cursor_overlay dut (.*);

  int checks = 0, failures = 0;
  int cycles = 0;
  int bp = 0;               // 0 always ready, 1 random, 2 stalled
  int unsigned tex_m [1024];
  logic [34:0] exp_q [4096];
  int wr_i = 0, rd_i = 0;
  int px = 0, py = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int scl(input int a, input int b);
    return (a * b + 127) / 255;
  endfunction

  function automatic logic [23:0] model(input int x, input int y, input logic [23:0] bg);
    int edge_len, dx, dy, t, sf, df, s, d, v;
    logic [23:0] r;
    edge_len = 32 << cur_size;
    dx = x - px; dy = y - py;
    if (!cur_en || dx < 0 || dy < 0 || dx >= edge_len || dy >= edge_len) return bg;
    t = int'(tex_m[((dy >> cur_size) * 32) + (dx >> cur_size)]);
    if (!blend_normal) return (((t >> 24) & 255) != 0) ? 24'(t) : bg;
    sf = blend_src_sel ? scl(blend_k1, (t >> 24) & 255) : int'(blend_k1);
    case (blend_dst_sel)
      2'd1: df = blend_k1;
      2'd2: df = 255 - scl(blend_k1, (t >> 24) & 255);
      default: df = 0;
    endcase
    for (int c = 0; c < 3; c++) begin
      s = (t >> (8 * c)) & 255;
      d = int'(bg[8*c +: 8]);
      v = (s * sf + d * df + 127) / 255;
      r[8*c +: 8] = 8'((v > 255) ? 255 : v);
    end
    return r;
  endfunction

  task automatic mon();
    logic [34:0] e;
    if (out_valid && out_ready) begin
      if (rd_i >= wr_i) chk(0, "R10", "unexpected beat", 0, 1);
      else begin
        e = exp_q[rd_i % 4096];
        chk(out_rgb == e[23:0], "R7", "pixel colour", out_rgb, e[23:0]);
        chk({out_sof, out_eol, out_alpha} == e[34:24], "R9", "markers/alpha",
            {out_sof, out_eol, out_alpha}, e[34:24]);
        rd_i++;
      end
    end
  endtask

  task automatic step(input bit v, input int x, input int y, input logic [23:0] bg,
                      input bit sof, input bit eol, output bit acc);
    @(negedge clk);
    in_valid = v; in_x = 14'(x); in_y = 14'(y); in_rgb = bg;
    in_alpha = bg[7:0] ^ 8'h5A; in_sof = sof; in_eol = eol;
    out_ready = (bp == 0) ? 1'b1 : (bp == 2) ? 1'b0 : 1'($urandom_range(0, 1));
    #1;
    mon();
    acc = v && in_ready;
    if (acc) begin
      exp_q[wr_i % 4096] = {sof, eol, bg[7:0] ^ 8'h5A, model(x, y, bg)};
      wr_i++;
    end
  endtask

  task automatic send(input int x, input int y, input bit sof, input bit eol);
    bit acc;
    logic [23:0] bg;
    bg = 24'((x * 41) ^ (y * 97) ^ 24'hA5C3E1);
    do step(1, x, y, bg, sof, eol, acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    for (int i = 0; i < 60 && rd_i < wr_i; i++) step(0, 0, 0, 0, 0, 0, acc);
    chk(rd_i == wr_i, "R10", "all beats delivered", rd_i, wr_i);
  endtask

  task automatic set_pos(input int x, input int y);
    px = x; py = y;
    cur_pos = {2'b11, 14'(y), 2'b11, 14'(x)};   // R2: junk in unused bits
  endtask

  task automatic sweep(input int x0, input int x1, input int xs, input int ys []);
    foreach (ys[k])
      for (int x = x0; x <= x1; x += xs) send(x, ys[k], (x == x0) && (k == 0), x + xs > x1);
    drain();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid == 0, "R12", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R12", "in_ready in reset", in_ready, 1);
    chk(clip_readback == 0, "R12", "clip_readback in reset", clip_readback, 0);
    rst_n = 1'b1;

    // R4: load image, alpha zero on every 7th texel
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      tex_m[i] = {((i % 7) == 0) ? 8'h00 : 8'((i * 53) & 255), 8'(i), 8'(i * 3), 8'(255 - (i & 255))};
      tex_wr_en = 1; tex_wr_addr = 10'(i); tex_wr_data = tex_m[i];
    end
    @(negedge clk); tex_wr_en = 0;

    // R11: clip readback and no effect
    @(negedge clk); cur_clip = 2'd2;
    @(negedge clk); chk(clip_readback == 2, "R11", "clip readback", clip_readback, 2);
    cur_clip = 2'd3;

    // R9: latency with idle pipe
    cur_en = 1; set_pos(100, 40);
    step(1, 105, 45, 24'h123456, 1, 1, acc);
    @(negedge clk); in_valid = 0;
    chk(out_valid == 0, "R9", "no output one edge after accept", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R9", "output two edges after accept", out_valid, 1);
    #1 mon();

    // R1 R2 R5 R6 R7: size 32, normal, k1*Ta source, 1-k1*Ta dest
    blend_normal = 1; blend_src_sel = 1; blend_dst_sel = 2; blend_k1 = 8'hFF;
    sweep(96, 136, 1, '{39, 40, 55, 71, 72});
    // R1 R8: size 64, legacy, random back-pressure (R10)
    bp = 1; cur_size = 1; set_pos(10, 3); blend_normal = 0;
    sweep(8, 76, 1, '{2, 3, 36, 66, 67});
    // R1 R4 R5 R6: size 128, K1 source, K1 dest
    cur_size = 2; set_pos(0, 0); blend_normal = 1; blend_src_sel = 0;
    blend_dst_sel = 1; blend_k1 = 8'd200;
    sweep(0, 130, 3, '{0, 64, 127, 128});
    // R1 R2: size 256 at the far corner, zero dest
    cur_size = 3; set_pos(16200, 16300); blend_dst_sel = 0; blend_k1 = 8'd128;
    sweep(16190, 16383, 1, '{16299, 16300, 16383});
    // R7: saturation, K1 source plus K1 dest
    cur_size = 0; set_pos(20, 20); blend_dst_sel = 1; blend_k1 = 8'hFF;
    sweep(18, 54, 1, '{20, 51});
    // R6: reserved dest encoding 3 acts as zero
    blend_dst_sel = 3; blend_src_sel = 1; blend_k1 = 8'd77;
    sweep(18, 54, 1, '{25});
    // R3: disabled overlay passes background
    cur_en = 0;
    sweep(18, 54, 1, '{25, 30});
    cur_en = 1;

    // R10: stall fills two stages, then input blocks and output holds
    bp = 2;
    step(1, 21, 21, 24'h010203, 0, 0, acc);
    step(1, 22, 21, 24'h040506, 0, 0, acc);
    step(1, 23, 21, 24'h070809, 0, 0, acc);
    chk(in_ready == 0, "R10", "in_ready low when full and stalled", in_ready, 0);
    chk(out_valid == 1, "R10", "out_valid under stall", out_valid, 1);
    held = out_rgb;
    repeat (3) step(0, 0, 0, 0, 0, 0, acc);
    chk(out_rgb == held, "R10", "output held under stall", out_rgb, held);
    bp = 0;
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule